// File: doc/BRIEF.md
# Expansion RAM Bank Control Register

This block holds one control bit for each 8K region of a 16-bit address space. Together the bits decide where internal RAM answers the processor. Single-bit output commands set or clear the bits. A command carries a bit address and a set/clear flag, and a strobe qualifies it. Each command touches exactly one bit. The block compares the current processor address against the region bits and raises a RAM-enable for that address.

The regions that normally hold the standard 32K memory expansion (0x2000–0x3FFF and 0xA000–0xFFFF) use inverted polarity. In those regions a cleared bit means RAM is on, so after reset the machine sees its usual expansion memory without any software action. In every other region a set bit means RAM is on. One region carries memory-mapped I/O, and the block never enables RAM there. The block does not copy ROM into RAM. Software reads back each stored bit at the same bit address it uses to write it.

Top module: `bank_ctrl`

## Requirements
- R1: After reset, `ram_en` is 1 for any address in regions 1, 5, 6 and 7 (0x2000–0x3FFF, 0xA000–0xFFFF) with no command issued. The region index is `cpu_addr[15:13]`.
- R2: After reset, `ram_en` is 0 for regions 0, 2, 3 and 4.
- R3: For regions 1, 5, 6 and 7 the control bit is inverted. Setting that bit turns RAM off in its region, and clearing it turns RAM back on.
- R4: For regions 0, 2 and 3, setting the control bit turns RAM on in that region and clearing it turns RAM off.
- R5: A command with `cmd_stb`=1 writes `cmd_set` (1 = set, 0 = clear) into bit `cmd_bit` on that rising clock edge. No other bit changes. Without the strobe, no bit changes.
- R6: Region 4 (0x8000–0x9FFF) holds memory-mapped I/O. `ram_en` is never 1 there, whatever the state of its bit.
- R7: `bit_rd` returns the raw stored bit (1 = set) at bit address `cmd_bit`, in the same cycle. For `cmd_bit` of 8 or more, `bit_rd` is 0 and a command to that address changes nothing.
- R8: `ram_en` follows `cpu_addr` combinationally, in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_stb | input | 1 | Command strobe; one bit write per cycle it is high |
| cmd_set | input | 1 | 1 sets the addressed bit, 0 clears it |
| cmd_bit | input | 4 | Bit address for commands and readback |
| cpu_addr | input | 16 | Current processor address |
| ram_en | output | 1 | Internal RAM serves `cpu_addr` |
| bit_rd | output | 1 | Stored state of bit `cmd_bit` |

## Verification
A command lands on the clock edge that samples its strobe, so its effect is due one edge after it is driven. Both `ram_en` and `bit_rd` are combinational from the stored bits and the current address, so they show that effect as soon as the edge settles. The bench drives each step shortly after a rising edge and queues the expected pair. The monitor compares the pair a few nanoseconds after the following rising edge, so each check lands exactly one register stage after its stimulus. Queries made without a strobe pass through the same path and check that the state held.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int unsigned ADDR_W_DEF  = 16;
  localparam int unsigned REG_BITS_DEF = 3;
  localparam int unsigned BIT_W_DEF    = 4;

  typedef enum logic {
    OP_CLR = 1'b0,
    OP_SET = 1'b1
  } bank_op_e;
endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/bank_bits.sv
module bank_bits
  import bank_pkg::*;
#(
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned BIT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  bank_op_e           wr_op,
  input  logic [BIT_W-1:0]   wr_idx,
  output logic [NUM_REG-1:0] bits_o,
  output logic               rd_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REG);
  localparam logic [BIT_W-1:0] LIMIT = BIT_W'(NUM_REG);

  logic               idx_ok;
  logic [NUM_REG-1:0] bits_q;
  logic [NUM_REG-1:0] bits_d;
  logic [NUM_REG-1:0] bit_ce;

  assign idx_ok = (wr_idx < LIMIT);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REG; gi++) begin : g_bit
      always_comb begin
        bit_ce[gi] = wr_en && idx_ok && (wr_idx[SEL_W-1:0] == SEL_W'(gi));
        bits_d[gi] = bit_ce[gi] ? (wr_op == OP_SET) : bits_q[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bits_q[gi] <= 1'b0;
        else if (bit_ce[gi]) bits_q[gi] <= bits_d[gi];
      end
    end
  endgenerate

  always_comb begin
    rd_o = idx_ok ? bits_q[wr_idx[SEL_W-1:0]] : 1'b0;
  end

  assign bits_o = bits_q;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits_q));
  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_ok) |=> (bits_q[$past(wr_idx[SEL_W-1:0])] == $past(wr_op == OP_SET)));
  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(bits_q ^ $past(bits_q)) <= 1));
  p_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idx_ok) |=> $stable(bits_q));
endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int unsigned             ADDR_W   = 16,
  parameter int unsigned             NUM_REG  = 8,
  parameter logic [NUM_REG-1:0]      STD_MASK = 8'hE2,
  parameter logic [NUM_REG-1:0]      IO_MASK  = 8'h10
) (
  input  logic [NUM_REG-1:0] bits_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               ram_en_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REG);

  logic [SEL_W-1:0]   region;
  logic [NUM_REG-1:0] reg_en;

  assign region = addr_i[ADDR_W-1 -: SEL_W];

  genvar gr;
  generate
    for (gr = 0; gr < NUM_REG; gr++) begin : g_reg
      if (IO_MASK[gr]) begin : g_io
        assign reg_en[gr] = 1'b0;
      end else if (STD_MASK[gr]) begin : g_std
        assign reg_en[gr] = ~bits_i[gr];
      end else begin : g_ext
        assign reg_en[gr] = bits_i[gr];
      end
    end
  endgenerate

  assign ram_en_o = reg_en[region];
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned REG_BITS = REG_BITS_DEF,
  parameter int unsigned BIT_W    = BIT_W_DEF,
  parameter logic [(1<<REG_BITS)-1:0] STD_MASK = 'hE2,
  parameter logic [(1<<REG_BITS)-1:0] IO_MASK  = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              cmd_set,
  input  logic [BIT_W-1:0]  cmd_bit,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              ram_en,
  output logic              bit_rd
);
  localparam int unsigned NUM_REG = 1 << REG_BITS;

  logic               rst_q;
  logic [NUM_REG-1:0] bits;
  bank_op_e           op;

  assign op = cmd_set ? OP_SET : OP_CLR;

  bank_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  bank_bits #(
    .NUM_REG (NUM_REG),
    .BIT_W   (BIT_W)
  ) u_bits (
    .clk    (clk),
    .rst_n  (rst_q),
    .wr_en  (cmd_stb),
    .wr_op  (op),
    .wr_idx (cmd_bit),
    .bits_o (bits),
    .rd_o   (bit_rd)
  );

  bank_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REG  (NUM_REG),
    .STD_MASK (STD_MASK),
    .IO_MASK  (IO_MASK)
  ) u_dec (
    .bits_i   (bits),
    .addr_i   (cpu_addr),
    .ram_en_o (ram_en)
  );

  p_io_never_r6: assert property (@(posedge clk) disable iff (!rst_q)
    IO_MASK[cpu_addr[ADDR_W-1 -: REG_BITS]] |-> !ram_en);
  p_std_polarity_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (STD_MASK[cpu_addr[ADDR_W-1 -: REG_BITS]] && !IO_MASK[cpu_addr[ADDR_W-1 -: REG_BITS]])
      |-> (ram_en != bits[cpu_addr[ADDR_W-1 -: REG_BITS]]));
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_q) && STD_MASK[cpu_addr[ADDR_W-1 -: REG_BITS]]
      && !IO_MASK[cpu_addr[ADDR_W-1 -: REG_BITS]]) |-> ram_en);
endmodule

// File: tb/bank_ctrl_bench.sv
module bank_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        cmd_stb;
  logic        cmd_set;
  logic [3:0]  cmd_bit;
  logic [15:0] cpu_addr;
  logic        ram_en;
  logic        bit_rd;

  typedef struct {
    logic  en;
    logic  rd;
    string req;
  } item_t;

  item_t q[$];
  int    total;
  int    bad;
  logic  [7:0] mbits;
  bit    done;

  bank_ctrl u_bank_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb),
    .cmd_set  (cmd_set),
    .cmd_bit  (cmd_bit),
    .cpu_addr (cpu_addr),
    .ram_en   (ram_en),
    .bit_rd   (bit_rd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic model_en(input logic [15:0] a);
    int r;
    r = int'(a[15:13]);
    case (r)
      4:          return 1'b0;
      1, 5, 6, 7: return ~mbits[r];
      default:    return mbits[r];
    endcase
  endfunction

  task automatic step(input logic stb, input logic st, input logic [3:0] b,
                      input logic [15:0] a, input string req);
    item_t it;
    @(posedge clk);
    #8;
    cmd_stb  = stb;
    cmd_set  = st;
    cmd_bit  = b;
    cpu_addr = a;
    if (stb && b < 4'd8) mbits[b[2:0]] = st;
    it.en  = model_en(a);
    it.rd  = (b < 4'd8) ? mbits[b[2:0]] : 1'b0;
    it.req = req;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (ram_en !== it.en || bit_rd !== it.rd) begin
          bad++;
          $display("FAIL %s: ram_en=%b bit_rd=%b expected ram_en=%b bit_rd=%b",
                   it.req, ram_en, bit_rd, it.en, it.rd);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0; mbits = 8'h00;
    rst_n = 1'b0; cmd_stb = 1'b0; cmd_set = 1'b0; cmd_bit = 4'd0; cpu_addr = 16'h0000;
    repeat (3) @(posedge clk);
    #8 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 / R2 reset state, R8 address follows each step
    step(0, 0, 4'd1, 16'h2000, "R1");
    step(0, 0, 4'd5, 16'hA000, "R1");
    step(0, 0, 4'd7, 16'hFFFE, "R1");
    step(0, 0, 4'd0, 16'h0000, "R2");
    step(0, 0, 4'd2, 16'h4000, "R2");
    step(0, 0, 4'd3, 16'h7FFF, "R2");
    step(0, 0, 4'd4, 16'h8000, "R2");
    // R3 inverted standard bit
    step(1, 1, 4'd1, 16'h3FFE, "R3");
    step(0, 0, 4'd5, 16'h2100, "R3");
    step(1, 1, 4'd6, 16'hC000, "R3");
    step(1, 0, 4'd1, 16'h2002, "R3");
    // R4 extra regions
    step(1, 1, 4'd2, 16'h4000, "R4");
    step(0, 0, 4'd3, 16'h6000, "R5");
    step(1, 1, 4'd3, 16'h6000, "R4");
    step(1, 0, 4'd2, 16'h5000, "R4");
    // R6 I/O region
    step(1, 1, 4'd4, 16'h8400, "R6");
    step(0, 0, 4'd4, 16'h9FFF, "R6");
    // R7 out of range
    step(1, 1, 4'd9, 16'h0000, "R7");
    step(1, 1, 4'd15, 16'hE000, "R7");
    step(0, 0, 4'd6, 16'hD000, "R7");
    // R8 address sweep, no strobe
    for (int r = 0; r < 8; r++) begin
      step(0, 0, 4'(r), 16'(r * 16'h2000 + 16'h0123), "R8");
    end
    // R5 set every bit one by one, then check all regions
    for (int r = 0; r < 8; r++) begin
      step(1, 1, 4'(r), 16'(r * 16'h2000), "R5");
    end
    for (int r = 0; r < 8; r++) begin
      step(0, 0, 4'(r), 16'(r * 16'h2000 + 16'h1FFF), "R5");
    end

    @(posedge clk);
    #8 cmd_stb = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule